// File: doc/BRIEF.md
# Read-Modify-Write Shift and Bit-Test Unit

This unit does the data work of the single-operand read-modify-write and bit-test instructions of an 8-bit processor. Each cycle it can accept one operation with these inputs:

- an operation code;
- the operand byte, taken from memory or from a register;
- the accumulator byte;
- the current carry.

One clock later it presents the byte to write back and a write strobe. It also presents carry, zero, overflow and negative flag values. Each flag has its own update strobe, so the processor's status register can merge only the flags the operation touches.

The supported operations are:

- shift left and logical shift right;
- rotate left and rotate right through carry;
- increment and decrement;
- bit test, in a memory form and an immediate form;
- test-and-set bits and test-and-reset bits.

Bus sequencing, address generation and cycle counting belong to the surrounding core.

When no operation is accepted, the registered outputs keep their values and all strobes drop. The same holds when the operation code is not one of the ten defined codes. The flag outputs therefore always show the most recent value written to each flag.

Top module: `rmw_unit`

## Requirements
- R1: Shift left (code 0) writes operand shifted left by one with 0 into bit 0. It copies operand bit 7 to carry and sets zero and negative from the result byte.
- R2: Logical shift right (code 1) writes operand shifted right with 0 into bit 7. It copies operand bit 0 to carry, sets negative to 0, and sets zero when operand bits 7:1 are all 0.
- R3: Rotate left (code 2) puts carry_in into bit 0, and rotate right (code 3) puts carry_in into bit 7. Both take the new carry from the bit shifted out and set zero and negative from the result.
- R4: Increment (code 4) and decrement (code 5) wrap modulo 256. They update only zero and negative, and carry is neither enabled nor changed.
- R5: Memory bit test (code 6) sets zero when accumulator AND operand is 0, copies operand bit 6 to overflow and bit 7 to negative, and leaves carry alone.
- R6: Immediate bit test (code 7) updates only zero, from accumulator AND operand.
- R7: Test-and-set (code 8) writes operand OR accumulator, and test-and-reset (code 9) writes operand AND NOT accumulator. Both set only zero, from the original operand AND accumulator.
- R8: A flag whose update strobe is low keeps its previous output value. The strobes are high exactly for the flags that the operation names.
- R9: The write strobe and result are registered with one cycle of latency. The strobe is high for one cycle after each accepted operation of codes 0-5, 8 and 9, and low after bit tests. The result holds while the strobe is low.
- R10: With op_valid low, or with a code of 10 to 15, the next cycle has every strobe low and the data and flag outputs unchanged.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 4 | Operation select (codes 0-9) |
| operand | input | 8 | Memory/register operand byte |
| acc | input | 8 | Accumulator byte |
| carry_in | input | 1 | Current carry flag |
| wb_data | output | 8 | Byte to write back |
| wb_en | output | 1 | Write-back strobe |
| flag_c | output | 1 | Carry value |
| flag_z | output | 1 | Zero value |
| flag_v | output | 1 | Overflow value |
| flag_n | output | 1 | Negative value |
| upd_c | output | 1 | Carry update strobe |
| upd_z | output | 1 | Zero update strobe |
| upd_v | output | 1 | Overflow update strobe |
| upd_n | output | 1 | Negative update strobe |

## Verification
The assertions assume that operand, acc, carry_in and op_code are defined (not X) whenever op_valid is high, and that they are only sampled at the clock edge at which op_valid is high. They make no assumption about back-to-back issue. The stimulus drives every input on the falling edge and holds it across the rising edge. It issues operations on consecutive cycles and also inserts idle cycles and undefined codes, so the hold rules can be seen.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int DW = 8;

  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_ROL  = 4'd2,
    OP_ROR  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_TSTM = 4'd6,
    OP_TSTI = 4'd7,
    OP_SETB = 4'd8,
    OP_CLRB = 4'd9
  } rmw_op_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          we;
    logic          c;
    logic          z;
    logic          v;
    logic          n;
    logic          c_en;
    logic          z_en;
    logic          v_en;
    logic          n_en;
  } rmw_res_t;

  function automatic logic f_is_zero(input logic [DW-1:0] b);
    return (b == '0);
  endfunction

  // shift by one; dir_left selects direction, fill is the inserted bit
  function automatic logic [DW-1:0] f_shift(input logic [DW-1:0] b,
                                            input logic dir_left,
                                            input logic fill);
    return dir_left ? {b[DW-2:0], fill} : {fill, b[DW-1:1]};
  endfunction

  function automatic logic f_out_bit(input logic [DW-1:0] b,
                                     input logic dir_left);
    return dir_left ? b[DW-1] : b[0];
  endfunction

endpackage

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit
  import rmw_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opd,
  input  logic         cin,
  output rmw_res_t     res,
  output logic         hit
);

  logic         dir_left;
  logic         use_cin;
  logic         is_shift;
  logic [W-1:0] sh_val;
  logic [W-1:0] cnt_val;

  always_comb begin
    dir_left = (op == OP_SHL) || (op == OP_ROL);
    use_cin  = (op == OP_ROL) || (op == OP_ROR);
    is_shift = (op == OP_SHL) || (op == OP_SHR) ||
               (op == OP_ROL) || (op == OP_ROR);
  end

  always_comb begin
    sh_val  = f_shift(opd, dir_left, use_cin ? cin : 1'b0);
    cnt_val = (op == OP_INC) ? opd + W'(1) : opd - W'(1);
  end

  always_comb begin
    res = '0;
    hit = 1'b0;
    if (is_shift) begin
      hit      = 1'b1;
      res.data = sh_val;
      res.we   = 1'b1;
      res.c    = f_out_bit(opd, dir_left);
      res.z    = f_is_zero(sh_val);
      res.n    = sh_val[W-1];
      res.c_en = 1'b1;
      res.z_en = 1'b1;
      res.n_en = 1'b1;
    end else if ((op == OP_INC) || (op == OP_DEC)) begin
      hit      = 1'b1;
      res.data = cnt_val;
      res.we   = 1'b1;
      res.z    = f_is_zero(cnt_val);
      res.n    = cnt_val[W-1];
      res.z_en = 1'b1;
      res.n_en = 1'b1;
    end
  end

endmodule

// File: rtl/rmw_bit_unit.sv
module rmw_bit_unit
  import rmw_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opd,
  input  logic [W-1:0] acc,
  output rmw_res_t     res,
  output logic         hit
);

  logic [W-1:0] common;
  logic         none_common;

  always_comb begin
    common      = opd & acc;
    none_common = f_is_zero(common);
  end

  always_comb begin
    res      = '0;
    hit      = 1'b0;
    res.z    = none_common;
    unique case (op)
      OP_TSTM: begin
        hit      = 1'b1;
        res.v    = opd[W-2];
        res.n    = opd[W-1];
        res.z_en = 1'b1;
        res.v_en = 1'b1;
        res.n_en = 1'b1;
      end
      OP_TSTI: begin
        hit      = 1'b1;
        res.z_en = 1'b1;
      end
      OP_SETB: begin
        hit      = 1'b1;
        res.data = opd | acc;
        res.we   = 1'b1;
        res.z_en = 1'b1;
      end
      OP_CLRB: begin
        hit      = 1'b1;
        res.data = opd & ~acc;
        res.we   = 1'b1;
        res.z_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rmw_out_reg.sv
module rmw_out_reg
  import rmw_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rmw_res_t     nxt,
  output rmw_res_t     cur
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else begin
      cur.we   <= nxt.we;
      cur.c_en <= nxt.c_en;
      cur.z_en <= nxt.z_en;
      cur.v_en <= nxt.v_en;
      cur.n_en <= nxt.n_en;
      if (nxt.we)   cur.data <= nxt.data;
      if (nxt.c_en) cur.c    <= nxt.c;
      if (nxt.z_en) cur.z    <= nxt.z;
      if (nxt.v_en) cur.v    <= nxt.v;
      if (nxt.n_en) cur.n    <= nxt.n;
    end
  end

  AST_HOLD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.c_en |-> $stable(cur.c)); // R8
  AST_HOLD_OVFL: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.v_en |-> $stable(cur.v)); // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.we |-> $stable(cur.data)); // R9

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] acc,
  input  logic         carry_in,
  output logic [W-1:0] wb_data,
  output logic         wb_en,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_n,
  output logic         upd_c,
  output logic         upd_z,
  output logic         upd_v,
  output logic         upd_n
);

  rmw_res_t shift_res, bit_res, nxt_res, cur_res;
  logic     shift_hit, bit_hit;
  logic     accept_shift, accept_bit;

  rmw_shift_unit #(.W(W)) u_shift (
    .op (op_code), .opd (operand), .cin (carry_in),
    .res(shift_res), .hit(shift_hit)
  );

  rmw_bit_unit #(.W(W)) u_bit (
    .op (op_code), .opd (operand), .acc (acc),
    .res(bit_res), .hit(bit_hit)
  );

  always_comb begin
    accept_shift = op_valid && shift_hit;
    accept_bit   = op_valid && bit_hit;
    if (accept_shift)    nxt_res = shift_res;
    else if (accept_bit) nxt_res = bit_res;
    else                 nxt_res = '0;
  end

  rmw_out_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .nxt(nxt_res), .cur(cur_res)
  );

  assign wb_data = cur_res.data;
  assign wb_en   = cur_res.we;
  assign flag_c  = cur_res.c;
  assign flag_z  = cur_res.z;
  assign flag_v  = cur_res.v;
  assign flag_n  = cur_res.n;
  assign upd_c   = cur_res.c_en;
  assign upd_z   = cur_res.z_en;
  assign upd_v   = cur_res.v_en;
  assign upd_n   = cur_res.n_en;

  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SHL) |=> (flag_c == $past(operand[W-1]))); // R1
  AST_SHR_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SHR) |=> (upd_n && !flag_n)); // R2
  AST_COUNT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> !upd_c); // R4
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_TSTM || op_code == OP_TSTI)) |=> !wb_en); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !(wb_en || upd_c || upd_z || upd_v || upd_n)); // R10
  AST_IMM_ZONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_TSTI) |=> (upd_z && !upd_c && !upd_v && !upd_n)); // R6

endmodule

// File: tb/rmw_unit_test.sv
module rmw_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc = '0;
  logic       carry_in = 1'b0;
  logic [7:0] wb_data;
  logic       wb_en, flag_c, flag_z, flag_v, flag_n;
  logic       upd_c, upd_z, upd_v, upd_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state
  int e_data = 0, e_we = 0, e_c = 0, e_z = 0, e_v = 0, e_n = 0;
  int e_uc = 0, e_uz = 0, e_uv = 0, e_un = 0;

  always #4 clk = ~clk;

  rmw_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc(acc), .carry_in(carry_in),
    .wb_data(wb_data), .wb_en(wb_en), .flag_c(flag_c), .flag_z(flag_z),
    .flag_v(flag_v), .flag_n(flag_n), .upd_c(upd_c), .upd_z(upd_z),
    .upd_v(upd_v), .upd_n(upd_n)
  );

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: returns result, and which flags/outputs change
  task automatic model(input int op, input int b, input int a, input int ci, input bit valid);
    int r = 0, c = 0, z = 0, v = 0, n = 0;
    bit we = 0, uc = 0, uz = 0, uv = 0, un = 0;
    if (valid) begin
      case (op)
        0: begin r = (b * 2) % 256; c = b / 128; we = 1; uc = 1; uz = 1; un = 1; end
        1: begin r = b / 2; c = b % 2; we = 1; uc = 1; uz = 1; un = 1; end
        2: begin r = (b * 2) % 256 + ci; c = b / 128; we = 1; uc = 1; uz = 1; un = 1; end
        3: begin r = b / 2 + ci * 128; c = b % 2; we = 1; uc = 1; uz = 1; un = 1; end
        4: begin r = (b + 1) % 256; we = 1; uz = 1; un = 1; end
        5: begin r = (b + 255) % 256; we = 1; uz = 1; un = 1; end
        6: begin uz = 1; uv = 1; un = 1; end
        7: begin uz = 1; end
        8: begin r = b | a; we = 1; uz = 1; end
        9: begin r = b & (255 - a); we = 1; uz = 1; end
        default: ;
      endcase
      if (op >= 6 && op <= 9) begin
        z = ((a & b) == 0) ? 1 : 0;
        v = (b / 64) % 2;
        n = b / 128;
      end else begin
        z = (r == 0) ? 1 : 0;
        n = r / 128;
      end
    end
    e_we = we; e_uc = uc; e_uz = uz; e_uv = uv; e_un = un;
    if (we) e_data = r;
    if (uc) e_c = c;
    if (uz) e_z = z;
    if (uv) e_v = v;
    if (un) e_n = n;
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "wb_data", int'(wb_data), e_data);
    cmp(tag, "flag_c", int'(flag_c), e_c);
    cmp(tag, "flag_z", int'(flag_z), e_z);
    cmp(tag, "flag_v", int'(flag_v), e_v);
    cmp(tag, "flag_n", int'(flag_n), e_n);
    cmp("R9", "wb_en", int'(wb_en), e_we);
    cmp("R8", "upd_c", int'(upd_c), e_uc);
    cmp("R8", "upd_z", int'(upd_z), e_uz);
    cmp("R8", "upd_v", int'(upd_v), e_uv);
    cmp("R8", "upd_n", int'(upd_n), e_un);
  endtask

  // drive at falling edge, result checked at the following falling edge
  task automatic issue(input int op, input int b, input int a, input int ci, input bit valid);
    op_valid = valid;
    op_code  = 4'(op);
    operand  = 8'(b);
    acc      = 8'(a);
    carry_in = 1'(ci);
    model(op, b, a, ci, valid);
    @(negedge clk);
    check_all(valid ? req_of(op) : "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    cmp("R11", "wb_data", int'(wb_data), 0);
    cmp("R11", "wb_en", int'(wb_en), 0);
    cmp("R11", "flags", int'({flag_c, flag_z, flag_v, flag_n}), 0);
    cmp("R11", "strobes", int'({upd_c, upd_z, upd_v, upd_n}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 10; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int b = 0; b < 256; b++) begin
          issue(op, b, (b * 37 + op * 11 + ci * 90) % 256, ci, 1'b1);
        end
      end
    end

    // corner cases: R2 shr zero with only bit 0 set, R4 wraps, R7 patterns
    issue(1, 8'h01, 0, 1, 1'b1);
    issue(4, 8'hFF, 0, 1, 1'b1);
    issue(5, 8'h00, 0, 0, 1'b1);
    issue(8, 8'h0F, 8'hF0, 0, 1'b1);
    issue(9, 8'hFF, 8'hFF, 0, 1'b1);
    issue(6, 8'hC0, 8'h3F, 0, 1'b1);
    // R10: idle cycles and undefined codes hold everything
    issue(0, 8'h81, 0, 0, 1'b1);
    issue(0, 8'h00, 0, 0, 1'b0);
    issue(0, 8'h00, 0, 0, 1'b0);
    for (int op = 10; op < 16; op++) issue(op, 8'h00, 8'hFF, 1, 1'b1);
    // R8: bit test after a flag-setting op keeps carry
    issue(3, 8'h01, 0, 0, 1'b1);
    issue(7, 8'h00, 8'h00, 0, 1'b1);
    issue(4, 8'h7F, 0, 0, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule